// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial characters through two register stages. A holding register takes a character from the parallel data inputs while an active-low load strobe is held low. The strobe's return to high asks for that character to be moved into a frame shifter. The shifter puts the character on the serial line, holding each bit for sixteen cycles of the transmit clock. If the shifter is still busy when the move is asked for, the move waits. The next character's start bit then follows the previous stop bit with no idle time between them.

The frame settings are data length (5 to 8 bits), parity on or off with even or odd sense, and one or two stop bits. They are read from the configuration inputs at the moment a character enters the shifter. Two flags report progress. `buf_empty` tells the host that the holding register may be written. `tx_empty` tells it that the line has fallen idle after the last stop bit. An active-high master clear returns the block to idle. It drives the line to mark and raises `buf_empty` at once, and it sets `tx_empty` on the next clock edge. The chip-level reset `rst_n` is asynchronous and active low, and its release is synchronised inside the block.

Top module: `uart_tx_dbuf`

## Requirements
- R1: While `ld_n` is sampled low on a clock edge, `ld_data` is captured into the holding register and `buf_empty` is low after that edge. Data presented while `ld_n` is high is not captured.
- R2: On the first edge that samples `ld_n` high after a low sample, an idle shifter takes the held character at that same edge. After that edge `tx_ser` is 0 (start bit), `buf_empty` is 1 and `tx_empty` is 0.
- R3: Each frame bit is held on `tx_ser` for exactly 16 clock cycles. The order is: one start bit at 0, the data bits least significant first, the parity bit if enabled, then the stop bits at 1.
- R4: `cfg_len` selects the data length: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits above the selected length are not sent.
- R5: With `cfg_par_en` = 1, one parity bit follows the data. `cfg_par_odd` = 0 gives even parity, where the bit is the XOR of the sent data bits. `cfg_par_odd` = 1 gives odd parity, which is the inverse of that XOR. With `cfg_par_en` = 0 no parity bit is sent.
- R6: `cfg_stop2` = 0 sends one stop bit and `cfg_stop2` = 1 sends two.
- R7: A move requested while a frame is shifting is deferred. The next start bit begins exactly where the last stop bit ends. `buf_empty` stays low until that move happens.
- R8: `tx_empty` rises only at the clock edge that ends the final stop bit, and only when no move is pending. It is 1 after reset.
- R9: While `mclr` is high, `tx_ser` and `buf_empty` are 1 without waiting for a clock edge. `tx_empty` is set by the first clock edge that samples `mclr` high. Any pending move is dropped.
- R10: The frame settings are sampled when a character enters the shifter, so changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| mclr | input | 1 | Active-high master clear |
| ld_n | input | 1 | Active-low load strobe for the holding register |
| ld_data | input | 8 | Parallel character to send |
| cfg_len | input | 2 | Data length select, 5 to 8 bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| tx_ser | output | 1 | Serial output, high at mark |
| buf_empty | output | 1 | Holding register may be written |
| tx_empty | output | 1 | Shifter idle after its last stop bit |

## Verification
Two events can fall on the same edge: a deferred move from the holding register and the end of the final stop bit of the frame now shifting. The bench provokes this by loading and releasing a second character while the first frame is only one bit old, and by changing the frame settings at that point. It then samples the line at mid-bit across both frames as one continuous stream, which must show no gap. The bench also judges that `buf_empty` stays low during the first frame's last bit and is high in the second frame's start bit, and that `tx_empty` never rises at the junction between the two frames.

// File: rtl/uart_txd_pkg.sv
package uart_txd_pkg;

  localparam int DATA_W   = 8;
  localparam int MIN_BITS = 5;
  // start + data + parity + two stops
  localparam int FRAME_W  = DATA_W + 4;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } frame_cfg_t;

  // Frame image, bit 0 goes out first; unused upper positions stay at mark.
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [DATA_W-1:0] d,
                                                    input frame_cfg_t c);
    logic [FRAME_W-1:0] f;
    logic               p;
    int                 n;
    n    = MIN_BITS + int'(c.len);
    f    = '1;
    f[0] = 1'b0;
    p    = c.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) begin
        f[1+i] = d[i];
        p      = p ^ d[i];
      end
    end
    if (c.par_en) f[1+n] = p;
    return f;
  endfunction

  function automatic logic [CNT_W-1:0] frame_bits(input frame_cfg_t c);
    return CNT_W'(2 + MIN_BITS + int'(c.len) + int'(c.par_en) + int'(c.stop2));
  endfunction

endpackage

// File: rtl/uart_txd_hold.sv
module uart_txd_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mclr,
  input  logic         ld_n,
  input  logic [W-1:0] ld_data,
  input  logic         grant,
  output logic [W-1:0] hold_data,
  output logic         req,
  output logic         empty
);

  logic [W-1:0] data_q;
  logic         data_en;
  logic         strb_q, strb_d;
  logic         pend_q, pend_d;
  logic         empty_q, empty_d;
  logic         rise;

  always_comb begin
    rise    = ld_n & ~strb_q;
    req     = (rise | pend_q) & ~mclr;
    data_en = ~ld_n & ~mclr;
    strb_d  = ld_n;
    pend_d  = req & ~grant;
    empty_d = empty_q;
    if (!ld_n)      empty_d = 1'b0;
    else if (grant) empty_d = 1'b1;
    if (mclr) begin
      strb_d  = 1'b1;
      pend_d  = 1'b0;
      empty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      strb_q  <= 1'b1;
      pend_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (data_en) data_q <= ld_data;
      strb_q  <= strb_d;
      pend_q  <= pend_d;
      empty_q <= empty_d;
    end
  end

  assign hold_data = data_q;
  assign empty     = empty_q;

endmodule

// File: rtl/uart_txd_shift.sv
module uart_txd_shift #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = 4,
  parameter int OVR     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mclr,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  output logic               ser,
  output logic               free,
  output logic               empty
);

  localparam int TICK_W = (OVR > 1) ? $clog2(OVR) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVR - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [TICK_W-1:0]  tick_q, tick_d;
  logic               empty_q, empty_d;
  logic               busy, bit_end, last_bit;

  always_comb begin
    busy     = (left_q != '0);
    bit_end  = busy & (tick_q == TICK_LAST);
    last_bit = (left_q == CNT_W'(1));
    free     = ~busy | (bit_end & last_bit);

    sh_d    = sh_q;
    left_d  = left_q;
    tick_d  = tick_q;
    empty_d = empty_q;
    if (load) begin
      sh_d    = frame_in;
      left_d  = nbits_in;
      tick_d  = '0;
      empty_d = 1'b0;
    end else if (bit_end) begin
      sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
      left_d = left_q - CNT_W'(1);
      tick_d = '0;
      if (last_bit) empty_d = 1'b1;
    end else if (busy) begin
      tick_d = tick_q + TICK_W'(1);
    end
    if (mclr) begin
      sh_d    = '1;
      left_d  = '0;
      tick_d  = '0;
      empty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '1;
      left_q  <= '0;
      tick_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      sh_q    <= sh_d;
      left_q  <= left_d;
      tick_q  <= tick_d;
      empty_q <= empty_d;
    end
  end

  assign ser   = sh_q[0];
  assign empty = empty_q;

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_txd_pkg::*;
#(
  parameter int OVR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              ld_n,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  output logic              tx_ser,
  output logic              buf_empty,
  output logic              tx_empty
);

  logic [1:0]         rs_q;
  logic               rst_int_n;
  logic [DATA_W-1:0]  hold_data;
  logic               req, grant, free;
  logic               hold_empty, ser_raw, sh_empty;
  frame_cfg_t         cfg;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    cfg   = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
    frame = pack_frame(hold_data, cfg);
    nbits = frame_bits(cfg);
    grant = req & free;
  end

  uart_txd_hold #(.W(DATA_W)) hold_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mclr      (mclr),
    .ld_n      (ld_n),
    .ld_data   (ld_data),
    .grant     (grant),
    .hold_data (hold_data),
    .req       (req),
    .empty     (hold_empty)
  );

  uart_txd_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .OVR(OVR)) shift_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .mclr     (mclr),
    .load     (grant),
    .frame_in (frame),
    .nbits_in (nbits),
    .ser      (ser_raw),
    .free     (free),
    .empty    (sh_empty)
  );

  assign tx_ser    = mclr | ser_raw;
  assign buf_empty = mclr | hold_empty;
  assign tx_empty  = sh_empty;

endmodule

// File: rtl/uart_txd_chk.sv
module uart_txd_chk (
  input logic clk,
  input logic rst_n,
  input logic mclr,
  input logic ld_n,
  input logic tx_ser,
  input logic buf_empty,
  input logic tx_empty
);

  // R1: a low strobe sample empties the holding register flag
  assert_load_clears_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && !mclr) |=> (!buf_empty || mclr));

  // R2: a move into the shifter puts the start bit on the line
  assert_start_on_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_empty) && !mclr) |-> !tx_ser);

  // R7: the holding flag only rises when the shifter takes the character
  assert_empty_rise_on_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(buf_empty) && !mclr) |-> !tx_empty);

  // R8: an idle transmitter holds the line at mark
  assert_idle_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !mclr) |-> tx_ser);

  // R8: idle is only reached after a stop bit at mark
  assert_idle_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_empty) && !$past(mclr)) |-> $past(tx_ser));

  // R9: master clear sets the transmitter-empty flag on the next edge
  assert_clear_sets_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> tx_empty);

endmodule

bind uart_tx_dbuf uart_txd_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mclr      (mclr),
  .ld_n      (ld_n),
  .tx_ser    (tx_ser),
  .buf_empty (buf_empty),
  .tx_empty  (tx_empty)
);

// File: tb/uart_tx_dbuf_tb.sv
`timescale 1ns/1ps
module uart_tx_dbuf_tb_top;

  logic       clk;
  logic       rst_n;
  logic       mclr;
  logic       ld_n;
  logic [7:0] ld_data;
  logic [1:0] cfg_len;
  logic       cfg_par_en, cfg_par_odd, cfg_stop2;
  logic       tx_ser, buf_empty, tx_empty;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  uart_tx_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .ld_n(ld_n), .ld_data(ld_data),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .tx_ser(tx_ser), .buf_empty(buf_empty), .tx_empty(tx_empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // cfg layout in the bench: {len[1:0], par_en, par_odd, stop2}
  function automatic logic [11:0] want_frame(input logic [7:0] d, input logic [4:0] c,
                                              output int n);
    logic [11:0] v;
    logic [7:0]  m;
    int          dl;
    dl = 5 + int'(c[4:3]);
    m  = 8'hFF >> (3 - int'(c[4:3]));
    v  = '1;
    v[0] = 1'b0;
    n  = 1;
    for (int i = 0; i < 8; i++) if (i < dl) begin v[n] = d[i]; n++; end
    if (c[2]) begin v[n] = c[1] ^ (^(d & m)); n++; end
    n = n + 1 + int'(c[0]);
    return v;
  endfunction

  // which requirement a given frame position belongs to
  function automatic string pos_tag(input logic [4:0] c, input int p);
    int dl;
    dl = 5 + int'(c[4:3]);
    if (p == 0) return "R3 start";
    if (p <= dl) return "R4 data";
    if (c[2] && p == dl + 1) return "R5 parity";
    return "R6 stop";
  endfunction

  task automatic set_cfg(input logic [4:0] c);
    {cfg_len, cfg_par_en, cfg_par_odd, cfg_stop2} = c;
  endtask

  // Send one frame, optionally queue a second one during bit 1 of the first
  task automatic run(input logic [7:0] da, input logic [4:0] ca,
                     input bit two, input logic [7:0] db, input logic [4:0] cb);
    logic [11:0] fa, fb;
    logic [23:0] stream;
    int na, nb, nt, p;
    fa = want_frame(da, ca, na);
    fb = want_frame(db, cb, nb);
    nb = two ? nb : 0;
    nt = na + nb;
    stream = {12'hFFF, fa} & ~(24'hFFF << na);
    stream = stream | ({12'h000, fb} << na) | (~24'h0 << nt);
    set_cfg(ca);
    @(negedge clk);
    ld_n = 1'b0; ld_data = da;
    @(negedge clk);
    chk(buf_empty == 1'b0, "R1 buf_empty after load", buf_empty, 0);
    ld_n = 1'b1; ld_data = ~da;
    @(posedge clk);
    @(negedge clk);
    chk(tx_ser == 1'b0, "R2 start bit at once", tx_ser, 0);
    chk(buf_empty == 1'b1, "R2 buf_empty after move", buf_empty, 1);
    chk(tx_empty == 1'b0, "R2 tx_empty after move", tx_empty, 0);
    repeat (7) @(negedge clk);
    for (int k = 0; k < nt; k++) begin
      p = (k < na) ? k : k - na;
      chk(tx_ser == stream[k], (k < na) ? pos_tag(ca, p) : {"R7 ", pos_tag(cb, p)},
          tx_ser, stream[k]);
      if (two && k == na - 1) chk(buf_empty == 1'b0, "R7 held until move", buf_empty, 0);
      if (two && k == na)     chk(buf_empty == 1'b1, "R7 moved at junction", buf_empty, 1);
      if (k < nt - 1 && two && k == na) chk(tx_empty == 1'b0, "R8 no idle at junction", tx_empty, 0);
      if (k == nt - 1) break;
      if (two && k == 1) begin
        ld_n = 1'b0; ld_data = db; set_cfg(cb);   // R10: new settings mid-frame
        @(negedge clk);
        chk(buf_empty == 1'b0, "R1 second load", buf_empty, 0);
        ld_n = 1'b1; ld_data = ~db;
        repeat (15) @(negedge clk);
      end else begin
        repeat (16) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    chk(tx_empty == 1'b0, "R8 busy through last stop", tx_empty, 0);
    @(negedge clk);
    chk(tx_empty == 1'b1, "R8 idle after last stop", tx_empty, 1);
    chk(tx_ser == 1'b1, "R8 line at mark", tx_ser, 1);
  endtask

  task automatic clear_test();
    int bad;
    set_cfg(5'b11101);
    @(negedge clk); ld_n = 1'b0; ld_data = 8'hA5;
    @(negedge clk); ld_n = 1'b1;
    repeat (40) @(negedge clk);
    ld_n = 1'b0; ld_data = 8'h3C;
    @(negedge clk); ld_n = 1'b1;
    repeat (3) @(negedge clk);
    mclr = 1'b1;
    #1;
    chk(tx_ser == 1'b1, "R9 line forced to mark", tx_ser, 1);
    chk(buf_empty == 1'b1, "R9 buf_empty forced", buf_empty, 1);
    chk(tx_empty == 1'b0, "R9 tx_empty waits for edge", tx_empty, 0);
    @(negedge clk);
    chk(tx_empty == 1'b1, "R9 tx_empty after edge", tx_empty, 1);
    mclr = 1'b0;
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tx_ser !== 1'b1 || tx_empty !== 1'b1) bad++;
    end
    chk(bad == 0, "R9 pending move dropped", bad, 0);
    chk(buf_empty == 1'b1, "R9 buf_empty stays high", buf_empty, 1);
  endtask

  initial begin
    rst_n = 1'b0; mclr = 1'b0; ld_n = 1'b1; ld_data = 8'h00;
    cfg_len = 2'b11; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_ser == 1'b1, "R8 reset line mark", tx_ser, 1);
    chk(buf_empty == 1'b1, "R8 reset buf_empty", buf_empty, 1);
    chk(tx_empty == 1'b1, "R8 reset tx_empty", tx_empty, 1);

    run(8'hFF, 5'b00000, 1'b0, 8'h00, 5'b0);   // R4: 5 bits, upper bits dropped
    run(8'h96, 5'b11111, 1'b0, 8'h00, 5'b0);   // R5 odd, R6 two stops
    run(8'h96, 5'b11100, 1'b0, 8'h00, 5'b0);   // R5 even
    run(8'h5A, 5'b11100, 1'b1, 8'hC3, 5'b00001); // R7, R10
    clear_test();
    run(8'h81, 5'b10110, 1'b0, 8'h00, 5'b0);

    for (int i = 0; i < 16; i++) begin
      run(8'($urandom), 5'($urandom), 1'($urandom), 8'($urandom), 5'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule